// File: doc/BRIEF.md
# Memory Fill Engine

The fill engine writes one constant word to every address of an inclusive range in an attached memory. After power-up it is used to zero the memory and, through the write path of the memory controller, to leave every word with a valid check code. Software loads a first address, a last address and a fill word over a small register write port, then writes an operation word. An operation word that carries the fill code starts a pass.

While the pass runs, the engine presents one write request per address on a valid/ready request interface, in ascending order. A `busy` output reports that a pass is in progress. Software polls it a bounded number of times and treats a pass that is still running after that as failed. To clear a memory of `size` words whose width code is `w`, software programs first address 0 and last address `(size << w) - 1`.

Top module: `mfill_engine`

## Requirements
- R1: After reset `busy` and `req_valid` are both low.
- R2: Register writes use `cfg_sel` 0 for the first address, 1 for the last address, 2 for the fill word and 3 for the operation word. In the operation word, bits [3:0] hold the operation code and bits [8:4] hold the lane enables. If an operation word with code 1 is written while idle and first <= last, `busy` and `req_valid` are high in the cycle after the write edge, and `req_addr` equals the first address.
- R3: A pass issues exactly one accepted request for each address from first to last inclusive, in ascending order. Every request carries the fill word on `req_data` and the lane enables on `req_lanes`.
- R4: The address advances only on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_valid`, `req_addr` and `req_data` hold their values.
- R5: `busy` and `req_valid` drop in the cycle after the request for the last address is accepted, and the pass completes within the polling budget that software allows.
- R6: When the first and last addresses are equal, exactly one request is issued.
- R7: An operation word written while `busy` is high neither restarts nor alters the running pass.
- R8: An operation word whose code is not 1 starts nothing and issues no request.
- R9: If the first address is greater than the last address, a fill operation starts nothing and issues no request.
- R10: Register writes made during a pass do not change the addresses or data of that pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | REG_W | Register write data |
| busy | output | 1 | Pass in progress |
| req_valid | output | 1 | Write request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W | Write request address |
| req_data | output | DATA_W | Write request data |
| req_lanes | output | LANE_W | Write request lane enables |

## Verification
A start takes effect at the edge that captures the operation word, so `busy` and the first request are checked at the falling edge after that write. Each accepted request is counted at the falling edge before the edge that accepts it. The bench changes `req_ready` only just after a rising edge, so the values seen at the falling edge are the ones the next rising edge acts on. A scoreboard queue holds the expected address and data sequence. The monitor compares every accepted request against it, and a request that arrives when the queue is empty is reported. Completion is polled at the rate software would use, and the bench then checks that the queue has drained.

// File: rtl/mfill_pkg.sv
package mfill_pkg;
   typedef enum logic [1:0] {
      SEL_FIRST = 2'd0,
      SEL_LAST  = 2'd1,
      SEL_FILL  = 2'd2,
      SEL_OP    = 2'd3
   } mf_sel_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } mf_state_e;

   localparam int unsigned OPC_FILL = 1;
endpackage

// File: rtl/mfill_regs.sv
module mfill_regs #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [ADDR_W-1:0] first_q,
   output logic [ADDR_W-1:0] last_q,
   output logic [DATA_W-1:0] fill_q
);
   import mfill_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= '0;
         last_q  <= '0;
         fill_q  <= '0;
      end else if (wr_en) begin
         case (mf_sel_e'(wr_sel))
            SEL_FIRST: first_q <= wr_data[ADDR_W-1:0];
            SEL_LAST:  last_q  <= wr_data[ADDR_W-1:0];
            SEL_FILL:  fill_q  <= wr_data[DATA_W-1:0];
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/mfill_addr_gen.sv
module mfill_addr_gen #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              adv,
   input  logic [ADDR_W-1:0] first_in,
   input  logic [ADDR_W-1:0] last_in,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              at_last
);
   logic [ADDR_W-1:0] stop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         stop_q   <= '0;
      end else if (load) begin
         cur_addr <= first_in;
         stop_q   <= last_in;
      end else if (adv) begin
         cur_addr <= cur_addr + 1'b1;
      end
   end

   assign at_last = (cur_addr == stop_q);
endmodule

// File: rtl/mfill_payload.sv
module mfill_payload #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned LANE_W       = 5,
   parameter bit          HOLD_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] fill_in,
   input  logic [LANE_W-1:0] lanes_in,
   output logic [DATA_W-1:0] data_out,
   output logic [LANE_W-1:0] lanes_out
);
   always_ff @(posedge clk) begin
      if (!rst_n)    lanes_out <= '0;
      else if (load) lanes_out <= lanes_in;
   end

   generate
      if (HOLD_PAYLOAD) begin : g_hold
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (!rst_n)    data_q <= '0;
            else if (load) data_q <= fill_in;
         end
         assign data_out = data_q;
      end else begin : g_live
         assign data_out = fill_in;
      end
   endgenerate
endmodule

// File: rtl/mfill_ctrl.sv
module mfill_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic accept,
   input  logic at_last,
   output logic busy
);
   import mfill_pkg::*;

   mf_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start)            state_d = ST_RUN;
         ST_RUN:  if (accept && at_last) state_d = ST_IDLE;
         default:                        state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign busy = (state_q == ST_RUN);
endmodule

// File: rtl/mfill_engine.sv
module mfill_engine #(
   parameter int unsigned REG_W        = 32,
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned OP_W         = 4,
   parameter int unsigned LANE_W       = 5,
   parameter bit          HOLD_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic              busy,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [DATA_W-1:0] req_data,
   output logic [LANE_W-1:0] req_lanes
);
   import mfill_pkg::*;

   localparam int unsigned OPWORD_W = OP_W + LANE_W;

   generate
      if (ADDR_W < 1 || ADDR_W > REG_W) begin : g_bad_addr
         $error("mfill_engine: ADDR_W must be between 1 and REG_W");
      end
      if (DATA_W < 1 || DATA_W > REG_W) begin : g_bad_data
         $error("mfill_engine: DATA_W must be between 1 and REG_W");
      end
      if (OP_W < 2 || LANE_W < 1 || OPWORD_W > REG_W) begin : g_bad_op
         $error("mfill_engine: operation word does not fit REG_W");
      end
   endgenerate

   logic [ADDR_W-1:0] first_q, last_q;
   logic [DATA_W-1:0] fill_q;
   logic              op_wr, start_go, accept, at_last;
   logic [OP_W-1:0]   op_code;
   logic [LANE_W-1:0] op_lanes;

   mfill_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_sel  (cfg_sel),
      .wr_data (cfg_wdata),
      .first_q (first_q),
      .last_q  (last_q),
      .fill_q  (fill_q)
   );

   assign op_wr    = cfg_we && (mf_sel_e'(cfg_sel) == SEL_OP);
   assign op_code  = cfg_wdata[OP_W-1:0];
   assign op_lanes = cfg_wdata[OP_W +: LANE_W];
   assign start_go = op_wr && !busy && (op_code == OP_W'(OPC_FILL))
                     && (first_q <= last_q);
   assign accept   = req_valid && req_ready;

   mfill_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_go),
      .accept  (accept),
      .at_last (at_last),
      .busy    (busy)
   );

   mfill_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_go),
      .adv      (accept && !at_last),
      .first_in (first_q),
      .last_in  (last_q),
      .cur_addr (req_addr),
      .at_last  (at_last)
   );

   mfill_payload #(.DATA_W(DATA_W), .LANE_W(LANE_W), .HOLD_PAYLOAD(HOLD_PAYLOAD)) u_pay (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_go),
      .fill_in   (fill_q),
      .lanes_in  (op_lanes),
      .data_out  (req_data),
      .lanes_out (req_lanes)
   );

   assign req_valid = busy;
endmodule

// File: rtl/mfill_engine_chk.sv
module mfill_engine_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_data,
   input logic              start_go,
   input logic              op_wr,
   input logic              at_last,
   input logic [ADDR_W-1:0] first_q
);
   // R2: a start makes the first request visible in the next cycle
   a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> busy && req_valid && req_addr == $past(first_q));

   // R4: back-pressure holds the request
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data));

   // R3: an accepted non-final request steps the address by one
   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !at_last |=> req_valid && req_addr == $past(req_addr) + 1'b1);

   // R5: acceptance of the last address ends the pass
   a_r5_done: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && at_last |=> !busy && !req_valid);

   // R7: an operation write during a pass does not move the address
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy && op_wr && !req_ready |=> busy && $stable(req_addr));
endmodule

bind mfill_engine mfill_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .req_data  (req_data),
   .start_go  (start_go),
   .op_wr     (op_wr),
   .at_last   (at_last),
   .first_q   (first_q)
);

// File: tb/mfill_engine_test.sv
module mfill_engine_test;
   localparam int REG_W = 32, ADDR_W = 16, DATA_W = 32, LANE_W = 5;
   localparam int EXP_W = ADDR_W + DATA_W + LANE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = 2'd0;
   logic [REG_W-1:0]  cfg_wdata = '0;
   logic              busy, req_valid;
   logic              req_ready = 1'b1;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_data;
   logic [LANE_W-1:0] req_lanes;

   int total = 0, bad = 0;
   logic [EXP_W-1:0] exp_q[$];
   bit   bp_mode = 1'b0;
   logic [7:0] lfsr = 8'h5a;

   mfill_engine uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .busy(busy), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
      .req_lanes(req_lanes)
   );

   always #5 clk = ~clk;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ready driver: changes just after each rising edge
   initial forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      req_ready = bp_mode ? lfsr[0] : 1'b1;
   end

   // monitor: compares accepted requests with the scoreboard (R3, R4)
   logic              prev_stall = 1'b0;
   logic [ADDR_W-1:0] prev_addr = '0;
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         if (prev_stall)
            check(req_valid && req_addr == prev_addr, "R4 hold under back-pressure", req_addr, prev_addr);
         if (req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R3 unexpected request", req_addr, '0);
            end else begin
               logic [EXP_W-1:0] e;
               e = exp_q.pop_front();
               check({req_addr, req_data, req_lanes} == e, "R3 request content",
                     {req_addr, req_data, req_lanes}, e);
            end
         end
         prev_stall = req_valid && !req_ready;
         prev_addr  = req_addr;
      end
   end

   task automatic reg_write(input logic [1:0] sel, input logic [REG_W-1:0] val);
      @(posedge clk); #2;
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(posedge clk); #2;
      cfg_we = 1'b0;
   endtask

   task automatic expect_fill(input int first, input int last, input logic [DATA_W-1:0] d,
                              input logic [LANE_W-1:0] ln);
      for (int a = first; a <= last; a++)
         exp_q.push_back({ADDR_W'(a), d, ln});
   endtask

   task automatic setup(input int first, input int last, input logic [DATA_W-1:0] d);
      reg_write(2'd0, REG_W'(first));
      reg_write(2'd1, REG_W'(last));
      reg_write(2'd2, d);
   endtask

   // poll busy as software would: at most 100 polls
   task automatic wait_done(input string req);
      for (int p = 0; p < 100; p++) begin
         repeat (8) @(negedge clk);
         if (!busy) break;
      end
      @(negedge clk);
      check(!busy && !req_valid, "R5 busy dropped within poll budget", busy, 0);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   task automatic start_and_check(input logic [REG_W-1:0] opw, input int first);
      reg_write(2'd3, opw);
      @(negedge clk);
      check(busy && req_valid && req_addr == ADDR_W'(first), "R2 start", req_addr, first);
   endtask

   task automatic expect_idle(input string req);
      repeat (10) begin
         @(negedge clk);
         check(!busy && !req_valid, req, busy, 0);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!busy && !req_valid, "R1 reset state", {busy, req_valid}, 0);
      @(posedge clk); #2; rst_n = 1'b1;

      // plain fill 0..7
      setup(0, 7, 32'ha5a5_a5a5);
      expect_fill(0, 7, 32'ha5a5_a5a5, 5'h1f);
      start_and_check(32'h1f1, 0);
      wait_done("R3 all addresses 0..7 written");

      // single word
      setup(10, 10, 32'h0000_1234);
      expect_fill(10, 10, 32'h0000_1234, 5'h03);
      start_and_check(32'h031, 10);
      wait_done("R6 single write");

      // back-pressure pass
      bp_mode = 1'b1;
      setup(32, 47, 32'hdead_beef);
      expect_fill(32, 47, 32'hdead_beef, 5'h15);
      start_and_check(32'h151, 32);
      wait_done("R4 all addresses under back-pressure");

      // first greater than last
      setup(5, 3, 32'h1);
      reg_write(2'd3, 32'h1f1);
      expect_idle("R9 reversed range ignored");

      // other operation code
      setup(0, 3, 32'h2);
      reg_write(2'd3, 32'h1f2);
      expect_idle("R8 other opcode ignored");

      // start and register writes during a pass
      setup(0, 15, 32'h0bad_f00d);
      expect_fill(0, 15, 32'h0bad_f00d, 5'h1f);
      start_and_check(32'h1f1, 0);
      repeat (2) @(posedge clk);
      reg_write(2'd0, 32'd100);
      reg_write(2'd2, 32'h7777_7777);
      reg_write(2'd1, 32'd200);
      reg_write(2'd3, 32'h0a1);
      wait_done("R7 R10 pass unchanged by writes while busy");

      // full clear: size 3 words, width code 2 -> last = (3<<2)-1 = 11
      bp_mode = 1'b0;
      setup(0, (3 << 2) - 1, 32'h0);
      expect_fill(0, 11, 32'h0, 5'h1f);
      start_and_check(32'h1f1, 0);
      wait_done("R3 full clear 0..11");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule